// File: doc/BRIEF.md
# JTAG Debug-Port Access Sequencer

This block is a hardware master that turns single debug-port (DP) and access-port (AP) register requests into JTAG scans. A host hands it one request at a time over a valid/ready port: which port to reach, address bits 3:2 of the register, a read/not-write flag and a 32-bit write word. The block then drives a separate shift engine, which owns the TAP state machine and TCK. It loads the instruction register when the access type changes. It runs the 35-bit data scan and decodes the 3-bit acknowledge.

Reads on this kind of port are posted: a scan only returns the data of the previous read. After every read, the sequencer therefore runs a trailing DP read of the read-buffer register, and that scan carries the data back. A WAIT acknowledge makes the block poll the DP control/status register until the target answers OK/FAULT. A cycle-count timeout ends the polling with an error. Each request ends with exactly one one-cycle `rsp_done` pulse, which carries the read data, the final acknowledge and an error flag.

Top module: `jtag_dp_sequencer`

## Requirements
- R1: Out of reset, `req_ready` is 1 and both `rsp_done` and `sh_start` are 0.
- R2: A data scan word is 35 bits with the header shifted first: bit 0 is the read flag (1 = read), bits 2:1 are register address bits 3:2, and bits 34:3 carry the write word (zero for reads). The request's own scan uses the request's fields.
- R3: Before a data scan, an instruction scan is issued whose low 4 bits are 4'hA for DP access or 4'hB for AP access. This happens when no instruction has been loaded since reset, or when the needed one differs from the last loaded. Otherwise the instruction scan is skipped.
- R4: Only one scan is outstanding at a time. `sh_start` is a one-cycle pulse, and the next pulse comes only after `sh_done` for the previous scan. So an instruction scan, with its return to Run-Test/Idle done by the engine, completes before the following data scan starts.
- R5: Every read request is followed by a DP read of the read-buffer register (header 3'b111). The data field of that scan is returned on `rsp_rdata`, and the acknowledge of the request's own read scan is ignored.
- R6: An acknowledge of 3'b010 (OK/FAULT) on the deciding scan ends the request with `rsp_error` = 0. Any value other than 3'b010 and 3'b001 ends it at once with `rsp_error` = 1 and no further scans. `rsp_ack` always reports the deciding scan's acknowledge.
- R7: A WAIT acknowledge (3'b001) makes the block issue DP reads of the control/status register (header 3'b011), one after another, until a different acknowledge arrives. That last poll scan then decides the result, and its data field is returned.
- R8: When a WAIT acknowledge arrives after `TIMEOUT_CYC` clock cycles of polling, the request ends with `rsp_error` = 1 and `rsp_ack` = 3'b001.
- R9: `rsp_done` pulses exactly once per accepted request, and `req_ready` is 0 from acceptance until after that pulse.
- R10: `sh_ir` and `sh_tx` hold steady while a scan is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken when valid |
| req_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| req_addr | input | 2 | Register address bits 3:2 |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 32 | Write word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Data field of the deciding scan |
| rsp_ack | output | 3 | Acknowledge of the deciding scan |
| rsp_error | output | 1 | Invalid acknowledge or timeout |
| sh_start | output | 1 | Start one scan on the shift engine |
| sh_ir | output | 1 | 1 = instruction scan, 0 = data scan |
| sh_tx | output | 35 | Bits to shift out, bit 0 first |
| sh_done | input | 1 | Scan finished, `sh_rx` valid |
| sh_rx | input | 35 | Bits captured, bit 0 first |

## Verification
The assertions assume a well-behaved shift engine. It raises `sh_done` for exactly one cycle per `sh_start`, never without a start, and only after at least one cycle. The host must hold its request fields only while `req_valid` is high. The bench's engine model answers every start after a fixed three-cycle delay and drives its request inputs on falling edges, only while `req_ready` is high, so the stimulus stays within those assumptions. The acknowledge script has a deliberate gap. It feeds nonsense acknowledges only to the posted read scans, where they must be ignored, and to the deciding scans of the invalid-acknowledge cases.

// File: rtl/dpseq_pkg.sv
// Shared types and constants of the debug-port access sequencer.
// Assumes a 3-bit acknowledge and a 32-bit data field per data scan.
package dpseq_pkg;
    localparam int HDR_W  = 3;
    localparam int DATA_W = 32;
    localparam int DR_W   = HDR_W + DATA_W;

    localparam logic [2:0] ACK_OK   = 3'b010;
    localparam logic [2:0] ACK_WAIT = 3'b001;

    localparam logic [1:0] ADDR_RDBUF = 2'b11;  // DP register 0xC
    localparam logic [1:0] ADDR_CTRL  = 2'b01;  // DP register 0x4

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_IR, S_IRW, S_DR, S_DRW, S_RSP
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_MAIN, PH_RDBUF, PH_POLL
    } seq_phase_t;
endpackage

// File: rtl/dpseq_scan_word.sv
// Builds the word handed to the shift engine.
// Instruction scans carry the code in the low bits; data scans carry the
// header {addr[3:2], rnw} first and the data word above it.
module dpseq_scan_word
    import dpseq_pkg::*;
#(
    parameter int IR_W = 4
) (
    input  logic              is_ir,
    input  logic [IR_W-1:0]   ir_code,
    input  logic [1:0]        addr,
    input  logic              rnw,
    input  logic [DATA_W-1:0] data,
    output logic [DR_W-1:0]   word
);
    // Select the instruction or data layout.
    always_comb begin
        if (is_ir) begin
            word             = '0;
            word[IR_W-1:0]   = ir_code;
        end else begin
            word = {data, addr, rnw};
        end
    end
endmodule

// File: rtl/dpseq_wait_timer.sv
// Saturating cycle counter that measures time spent polling on WAIT.
// Assumes clear and enable are never needed in the same cycle.
module dpseq_wait_timer #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    // Count enabled cycles, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (enable && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);

    // R8
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired && !clear |=> expired || $past(clear));
endmodule

// File: rtl/jtag_dp_sequencer.sv
// Turns DP/AP register requests into instruction and data scans on a shift
// engine. It posts reads and fetches them with a read-buffer scan, and it
// polls on WAIT with a timeout. Assumes the engine gives one sh_done per
// sh_start and returns the TAP to Run-Test/Idle after every scan.
module jtag_dp_sequencer
    import dpseq_pkg::*;
#(
    parameter int          IR_W        = 4,
    parameter logic [IR_W-1:0] DP_IR_CODE = 4'hA,
    parameter logic [IR_W-1:0] AP_IR_CODE = 4'hB,
    parameter int          TIMEOUT_CYC = 1000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_ap,
    input  logic [1:0]    req_addr,
    input  logic          req_rnw,
    input  logic [31:0]   req_wdata,
    output logic          rsp_done,
    output logic [31:0]   rsp_rdata,
    output logic [2:0]    rsp_ack,
    output logic          rsp_error,
    output logic          sh_start,
    output logic          sh_ir,
    output logic [34:0]   sh_tx,
    input  logic          sh_done,
    input  logic [34:0]   sh_rx
);
    seq_state_t  state;
    seq_phase_t  phase;
    logic        ap_q, rnw_q, cur_ap, ir_valid;
    logic [1:0]  addr_q;
    logic [31:0] wdata_q;
    logic        tgt_ap, expired, accept;
    logic [1:0]  dr_addr;
    logic        dr_rnw;
    logic [31:0] dr_data;
    logic [2:0]  rx_ack;

    assign accept    = (state == S_IDLE) && req_valid;
    assign req_ready = (state == S_IDLE);
    assign rsp_done  = (state == S_RSP);
    assign sh_start  = (state == S_IR) || (state == S_DR);
    assign sh_ir     = (state == S_IR) || (state == S_IRW);
    assign rx_ack    = sh_rx[2:0];

    // Pick the target port and scan header for the current phase.
    always_comb begin
        tgt_ap  = 1'b0;
        dr_rnw  = 1'b1;
        dr_data = '0;
        dr_addr = ADDR_CTRL;
        case (phase)
            PH_MAIN: begin
                tgt_ap  = ap_q;
                dr_rnw  = rnw_q;
                dr_addr = addr_q;
                dr_data = rnw_q ? '0 : wdata_q;
            end
            PH_RDBUF: dr_addr = ADDR_RDBUF;
            default:  dr_addr = ADDR_CTRL;
        endcase
    end

    dpseq_scan_word #(.IR_W(IR_W)) u_word (
        .is_ir   (sh_ir),
        .ir_code (tgt_ap ? AP_IR_CODE : DP_IR_CODE),
        .addr    (dr_addr),
        .rnw     (dr_rnw),
        .data    (dr_data),
        .word    (sh_tx)
    );

    dpseq_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .enable  (phase == PH_POLL && state != S_IDLE),
        .expired (expired)
    );

    // Sequence the scans of one request and record its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            phase     <= PH_MAIN;
            ap_q      <= 1'b0;
            rnw_q     <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            cur_ap    <= 1'b0;
            ir_valid  <= 1'b0;
            rsp_rdata <= '0;
            rsp_ack   <= '0;
            rsp_error <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    ap_q    <= req_ap;
                    rnw_q   <= req_rnw;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    phase   <= PH_MAIN;
                    state   <= S_ISSUE;
                end
                S_ISSUE: state <= (ir_valid && cur_ap == tgt_ap) ? S_DR : S_IR;
                S_IR:    state <= S_IRW;
                S_IRW: if (sh_done) begin
                    cur_ap   <= tgt_ap;
                    ir_valid <= 1'b1;
                    state    <= S_DR;
                end
                S_DR:    state <= S_DRW;
                S_DRW: if (sh_done) begin
                    rsp_rdata <= sh_rx[34:3];
                    rsp_ack   <= rx_ack;
                    if (phase == PH_MAIN && rnw_q) begin
                        phase <= PH_RDBUF;
                        state <= S_ISSUE;
                    end else if (rx_ack == ACK_OK) begin
                        rsp_error <= 1'b0;
                        state     <= S_RSP;
                    end else if (rx_ack == ACK_WAIT && !expired) begin
                        phase <= PH_POLL;
                        state <= S_ISSUE;
                    end else begin
                        rsp_error <= 1'b1;
                        state     <= S_RSP;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done && req_ready);
    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    // R6
    ok_means_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && !rsp_error |-> rsp_ack == ACK_OK);
    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRW || state == S_IRW) && $past(state) == state |-> $stable(sh_tx) && $stable(sh_ir));
    // R3
    ir_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start && sh_ir |-> sh_tx[IR_W-1:0] == DP_IR_CODE || sh_tx[IR_W-1:0] == AP_IR_CODE);
    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |=> !sh_start);
    // R5
    rdbuf_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start && !sh_ir && phase != PH_MAIN |-> sh_tx[0] && sh_tx[34:3] == '0);
endmodule

// File: tb/jtag_dp_sequencer_test.sv
module jtag_dp_sequencer_test;
    localparam int TMO = 100;
    localparam logic [2:0] OK = 3'b010, WT = 3'b001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ap = 1'b0, req_rnw = 1'b0;
    logic [1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_done, rsp_error, sh_start, sh_ir;
    logic [31:0] rsp_rdata;
    logic [2:0] rsp_ack;
    logic [34:0] sh_tx;
    logic sh_done = 1'b0;
    logic [34:0] sh_rx = '0;

    always #10 clk = ~clk;

    jtag_dp_sequencer #(.TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ap(req_ap), .req_addr(req_addr), .req_rnw(req_rnw), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_ack(rsp_ack), .rsp_error(rsp_error),
        .sh_start(sh_start), .sh_ir(sh_ir), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx)
    );

    int vectors = 0, fails = 0;
    int gdr = 0, req_dr = 0, log_n = 0, done_cnt = 0;
    int unstable = 0, overlap = 0, cyc = 0;
    logic [2:0]  ack_seq [64];
    logic        log_ir  [64];
    logic [34:0] log_tx  [64];
    logic        exp_ir  [64];
    logic [34:0] exp_tx  [64];
    int exp_n = 0, ndr = 0;
    logic bv = 1'b0, bir = 1'b0;

    // Shift engine model: fixed latency, scripted acknowledges.
    int busy = 0;
    logic        held_ir;
    logic [34:0] held_tx;
    always @(posedge clk) begin
        sh_done <= 1'b0;
        if (rsp_done) done_cnt++;
        if (busy > 0) begin
            if (sh_start) overlap++;
            if (sh_ir !== held_ir || sh_tx !== held_tx) unstable++;
            busy--;
            if (busy == 0) begin
                sh_done <= 1'b1;
                if (held_ir) sh_rx <= '0;
                else begin
                    sh_rx <= {32'hC0DE0000 + 32'(gdr), (req_dr < 64) ? ack_seq[req_dr] : WT};
                    gdr++;
                    req_dr++;
                end
            end
        end else if (sh_start) begin
            held_ir = sh_ir;
            held_tx = sh_tx;
            if (log_n < 64) begin
                log_ir[log_n] = sh_ir;
                log_tx[log_n] = sh_tx;
            end
            log_n++;
            busy = 3;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: act=expired exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic push(input logic tgt, input logic [34:0] w);
        if (!bv || bir != tgt) begin
            exp_ir[exp_n] = 1'b1;
            exp_tx[exp_n] = {31'b0, tgt ? 4'hB : 4'hA};
            exp_n++;
        end
        bv = 1'b1;
        bir = tgt;
        exp_ir[exp_n] = 1'b0;
        exp_tx[exp_n] = w;
        exp_n++;
        ndr++;
    endtask

    task automatic run_req(input logic ap, input logic [1:0] addr, input logic rnw,
                           input logic [31:0] wd, input int nwait,
                           input logic [2:0] fin, input logic [2:0] bogus);
        int first = rnw ? 1 : 0;
        bit tmo = (fin == WT);
        int gstart;
        int seq_bad = 0;
        int waitc = 0;
        logic [31:0] got_d;
        logic [2:0] got_a;
        logic got_e;
        for (int k = 0; k < 64; k++) begin
            if (k < first) ack_seq[k] = bogus;
            else if (tmo || k < first + nwait) ack_seq[k] = WT;
            else if (k == first + nwait) ack_seq[k] = fin;
            else ack_seq[k] = OK;
        end
        exp_n = 0; ndr = 0;
        gstart = gdr;
        push(ap, {rnw ? 32'b0 : wd, addr, rnw});
        if (rnw) push(1'b0, {32'b0, 2'b11, 1'b1});
        if (!tmo) for (int w = 0; w < nwait; w++) push(1'b0, {32'b0, 2'b01, 1'b1});
        else begin bv = 1'b1; bir = 1'b0; end
        log_n = 0; req_dr = 0; done_cnt = 0;
        req_ap = ap; req_addr = addr; req_rnw = rnw; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 ready low while busy", {63'b0, req_ready}, 64'd0);
        while (!rsp_done && waitc < 5000) begin @(negedge clk); waitc++; end
        got_d = rsp_rdata; got_a = rsp_ack; got_e = rsp_error;
        @(negedge clk); @(negedge clk);
        chk("R9 one done pulse", 64'(done_cnt), 64'd1);
        chk(tmo ? "R8 ack" : "R6 R7 ack", {61'b0, got_a}, {61'b0, fin});
        chk(tmo ? "R8 error" : "R6 error", {63'b0, got_e}, {63'b0, fin != OK});
        if (!tmo) begin
            if (log_n != exp_n) seq_bad = 1;
            else for (int i = 0; i < exp_n; i++)
                if (log_ir[i] !== exp_ir[i] || log_tx[i] !== exp_tx[i]) seq_bad = 1;
            chk("R2 R3 R5 R7 scan sequence", 64'(seq_bad), 64'd0);
            chk("R5 R7 rdata", {32'b0, got_d}, {32'b0, 32'hC0DE0000 + 32'(gstart + ndr - 1)});
        end else begin
            chk("R8 polled before timeout", 64'(log_n > first + 5), 64'd1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", {63'b0, req_ready}, 64'd1);
        chk("R1 done", {63'b0, rsp_done}, 64'd0);
        chk("R1 start", {63'b0, sh_start}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Sweep every port/address/direction combination, with 0..2 waits.
        for (int pass = 0; pass < 2; pass++)
            for (int c = 0; c < 8; c++)
                run_req(c[0] ^ pass[0], 2'(c >> 1), c[1], 32'h1000_0000 * c + 32'h55AA + pass,
                        (c + pass) % 3, OK, c[0] ? 3'b111 : WT);
        // R6 invalid acknowledges on the deciding scan.
        for (int a = 0; a < 8; a++)
            if (a != 1 && a != 2) run_req(a[0], 2'(a), a[1], 32'hDEAD_0000 + a, a % 2, 3'(a), 3'b000);
        // R3 back-to-back AP writes: second one skips the instruction scan.
        run_req(1'b1, 2'b01, 1'b0, 32'h0BAD_F00D, 0, OK, OK);
        run_req(1'b1, 2'b10, 1'b0, 32'h1234_5678, 0, OK, OK);
        // R8 endless WAIT, then recovery with a read.
        run_req(1'b1, 2'b11, 1'b0, 32'hFEED_BEEF, 0, WT, OK);
        run_req(1'b1, 2'b00, 1'b1, 32'h0, 1, OK, 3'b100);
        chk("R4 no overlapping starts", 64'(overlap), 64'd0);
        chk("R10 scan inputs stable", 64'(unstable), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule